// File: doc/BRIEF.md
# Serial-Memory Status Register Write Path with Hardware Write Protect

This block is the status-register write path of a serial memory slave on an SPI bus. It watches the chip-select, serial clock and serial data pins and recognises the write-status instruction: opcode 0x01 followed by one data byte. When the frame is complete and every guard allows it, the block starts a self-timed internal write. That write takes a configurable number of system clock cycles and then commits the writable status bits.

Only three status bits can be changed by software: two block-protect bits and a protect-enable bit. When protect-enable is set, a hardware write-protect input can veto the update. Pulling that input low at any point while chip select is active cancels the update. Once the internal write has begun, the input no longer has any effect on it. The write-enable latch lives outside the block. Its value arrives as an input, and the block emits a one-cycle clear pulse when a write finishes. All pins are sampled with the system clock, so the serial clock must be several times slower than that clock.

Top module: `spi_sr_wp`

## Requirements
- R1: After reset, `status` reads 0x00, `wel_clr` is low and `so_oe` is low.
- R2: A frame is the bits sampled on rising `sck` edges while `cs_n` is low, MSB first. An internal write starts on the `cs_n` rising edge only when exactly 16 bits were received and the first 8 equal 0x01. Any other bit count or opcode is discarded.
- R3: The data byte's bit 7 becomes protect-enable and its bits 3..2 become the block-protect pair, at the same positions in `status`. Data bits 6..4, 1 and 0 have no effect. `status[6:4]` reads 0, `status[1]` mirrors `wel` and `status[0]` is the busy flag.
- R4: A write starts only if `wel` is high at the `cs_n` rising edge. When the write completes, `wel_clr` is high for exactly one cycle.
- R5: If protect-enable (`status[7]`) is 1 and `wp_n` is low at the `cs_n` rising edge, the write is inhibited.
- R6: If protect-enable is 1 and `wp_n` is low at any sampled cycle while `cs_n` is low, the write is cancelled, even if `wp_n` returns high before `cs_n` rises.
- R7: Once the internal write has started, `wp_n` going low does not stop the commit.
- R8: When protect-enable is 0, `wp_n` is ignored.
- R9: `status[0]` is 1 for exactly `WCYC` cycles, starting the cycle after the start edge. The writable bits stay unchanged while it is 1 and update as it falls. A write instruction that ends during this time is ignored.
- R10: `so_oe` stays low at all times, so the serial output is never driven.
- R11: Frames sent in mode 0 (`sck` idle low) and in mode 3 (`sck` idle high) are both accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | SPI chip select, active low |
| sck | input | 1 | SPI serial clock |
| si | input | 1 | SPI serial data in |
| wp_n | input | 1 | Hardware write protect, active low |
| wel | input | 1 | Write-enable latch value |
| so | output | 1 | SPI serial data out (value; never enabled) |
| so_oe | output | 1 | Output enable for `so` |
| status | output | 8 | Status byte: protect-enable, block-protect pair, wel, busy |
| wel_clr | output | 1 | One-cycle pulse that clears the write-enable latch |

## Verification
The bench sends frames of 15 and 17 bits and a frame with opcode 0x02. A design that counted bits loosely, or started on the 16th edge, would commit these frames. It drops `wp_n` in the middle of a frame and restores it before chip select rises. A design that only looked at the pin's level at the end of the frame would then commit a write that should have been cancelled. It also drops `wp_n` after the internal write has started, where a design that gated the commit on the pin would lose a legal update. It writes all ones to show that only three bits move. It sends a second frame while busy, which a design without the busy lockout would accept.

// File: rtl/spi_sr_pkg.sv
package spi_sr_pkg;

    localparam int SR_W     = 8;
    localparam int OP_W     = 8;
    localparam int DAT_W    = 8;
    localparam int FRAME_W  = OP_W + DAT_W;

    localparam logic [OP_W-1:0] OP_SR_WRITE = 8'h01;

    localparam int POS_PEN  = 7;
    localparam int POS_BPH  = 3;
    localparam int POS_BPL  = 2;

    typedef struct packed {
        logic       pen;
        logic [1:0] bp;
    } sr_keep_t;

    function automatic sr_keep_t sr_pick(input logic [DAT_W-1:0] d);
        sr_keep_t k;
        k.pen = d[POS_PEN];
        k.bp  = d[POS_BPH:POS_BPL];
        return k;
    endfunction

    function automatic logic [SR_W-1:0] sr_pack(input sr_keep_t k,
                                                input logic wel,
                                                input logic busy);
        logic [SR_W-1:0] s;
        s                  = '0;
        s[POS_PEN]         = k.pen;
        s[POS_BPH:POS_BPL] = k.bp;
        s[1]               = wel;
        s[0]               = busy;
        return s;
    endfunction

endpackage

// File: rtl/spi_sr_shifter.sv
module spi_sr_shifter
    import spi_sr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cs_n,
    input  logic             sck,
    input  logic             si,
    output logic             frame_ok,
    output logic             cs_fall,
    output logic [DAT_W-1:0] frame_data
);

    localparam int CNT_MAX = FRAME_W + 1;
    localparam int CW      = $clog2(CNT_MAX + 1);

    logic               sck_q;
    logic               cs_q;
    logic               sck_rise;
    logic               cs_rise;
    logic [FRAME_W-1:0] shreg;
    logic [CW-1:0]      cnt;

    assign sck_rise = sck & ~sck_q & ~cs_n;
    assign cs_fall  = ~cs_n & cs_q;
    assign cs_rise  = cs_n & ~cs_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_q <= 1'b0;
            cs_q  <= 1'b1;
            shreg <= '0;
            cnt   <= '0;
        end else begin
            sck_q <= sck;
            cs_q  <= cs_n;
            if (cs_fall) begin
                cnt   <= '0;
                shreg <= '0;
            end else if (sck_rise) begin
                shreg <= {shreg[FRAME_W-2:0], si};
                if (cnt != CW'(CNT_MAX))
                    cnt <= cnt + 1'b1;
            end
        end
    end

    assign frame_data = shreg[DAT_W-1:0];
    assign frame_ok   = cs_rise && (cnt == CW'(FRAME_W)) &&
                        (shreg[FRAME_W-1 -: OP_W] == OP_SR_WRITE);

endmodule

// File: rtl/spi_sr_guard.sv
module spi_sr_guard (
    input  logic clk,
    input  logic rst,
    input  logic cs_n,
    input  logic cs_fall,
    input  logic wp_n,
    input  logic pen,
    output logic permit
);

    logic veto_now;
    logic killed;

    assign veto_now = pen & ~wp_n;

    always_ff @(posedge clk) begin
        if (rst)
            killed <= 1'b0;
        else if (cs_fall)
            killed <= veto_now;
        else if (~cs_n && veto_now)
            killed <= 1'b1;
    end

    assign permit = ~killed & ~veto_now;

endmodule

// File: rtl/spi_sr_wcycle.sv
module spi_sr_wcycle
    import spi_sr_pkg::*;
#(
    parameter int WCYC = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [DAT_W-1:0] din,
    output sr_keep_t         keep,
    output logic             busy,
    output logic             wel_clr
);

    localparam int TW = (WCYC > 1) ? $clog2(WCYC) : 1;

    logic [TW-1:0] tmr;
    sr_keep_t      pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            tmr     <= '0;
            pend    <= '0;
            keep    <= '0;
            wel_clr <= 1'b0;
        end else begin
            wel_clr <= 1'b0;
            if (start && !busy) begin
                busy <= 1'b1;
                tmr  <= TW'(WCYC - 1);
                pend <= sr_pick(din);
            end else if (busy) begin
                if (tmr == '0) begin
                    busy    <= 1'b0;
                    keep    <= pend;
                    wel_clr <= 1'b1;
                end else begin
                    tmr <= tmr - 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/spi_sr_wp.sv
module spi_sr_wp
    import spi_sr_pkg::*;
#(
    parameter int WCYC = 64
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cs_n,
    input  logic            sck,
    input  logic            si,
    input  logic            wp_n,
    input  logic            wel,
    output logic            so,
    output logic            so_oe,
    output logic [SR_W-1:0] status,
    output logic            wel_clr
);

    logic             frame_ok;
    logic             cs_fall;
    logic [DAT_W-1:0] frame_data;
    logic             permit;
    logic             busy;
    logic             start;
    sr_keep_t         keep;

    spi_sr_shifter u_shift (
        .clk        (clk),
        .rst        (rst),
        .cs_n       (cs_n),
        .sck        (sck),
        .si         (si),
        .frame_ok   (frame_ok),
        .cs_fall    (cs_fall),
        .frame_data (frame_data)
    );

    spi_sr_guard u_guard (
        .clk     (clk),
        .rst     (rst),
        .cs_n    (cs_n),
        .cs_fall (cs_fall),
        .wp_n    (wp_n),
        .pen     (keep.pen),
        .permit  (permit)
    );

    assign start = frame_ok & wel & permit & ~busy;

    spi_sr_wcycle #(.WCYC(WCYC)) u_wcyc (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .din     (frame_data),
        .keep    (keep),
        .busy    (busy),
        .wel_clr (wel_clr)
    );

    assign status = sr_pack(keep, wel, busy);
    assign so     = 1'b0;
    assign so_oe  = 1'b0;

endmodule

// File: rtl/spi_sr_wp_chk.sv
module spi_sr_wp_chk #(
    parameter int WCYC = 64
) (
    input logic       clk,
    input logic       rst,
    input logic       cs_n,
    input logic       wp_n,
    input logic       wel,
    input logic [7:0] status,
    input logic       wel_clr
);

    logic        busy;
    logic [31:0] busy_run;

    assign busy = status[0];

    always_ff @(posedge clk) begin
        if (rst)       busy_run <= '0;
        else if (busy) busy_run <= busy_run + 1;
        else           busy_run <= '0;
    end

    a_r4_wel_needed: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(wel));

    a_r5_wp_blocks_start: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> !($past(status[7]) && !$past(wp_n)));

    a_r9_bits_hold_while_busy: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(status[7:2]));

    a_r9_busy_length: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (busy_run == 32'(WCYC)));

    a_r4_clr_after_done: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> wel_clr);

    a_r4_clr_single: assert property (@(posedge clk) disable iff (rst)
        wel_clr |=> !wel_clr);

    a_r2_start_on_cs_rise: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(cs_n));

endmodule

bind spi_sr_wp spi_sr_wp_chk #(.WCYC(WCYC)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .cs_n    (cs_n),
    .wp_n    (wp_n),
    .wel     (wel),
    .status  (status),
    .wel_clr (wel_clr)
);

// File: tb/spi_sr_wp_bench.sv
module spi_sr_wp_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WCYC       = 120;

    typedef struct {
        logic [7:0] exp;
        int         clr_exp;
        string      req;
    } item_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n = 1'b1;
    logic       sck = 1'b0;
    logic       si = 1'b0;
    logic       wp_n = 1'b1;
    logic       wel = 1'b0;
    logic       so;
    logic       so_oe;
    logic [7:0] status;
    logic       wel_clr;

    int checks = 0;
    int errors = 0;
    int clr_seen = 0;
    int busy_cnt = 0;
    int busy_last = 0;
    bit done = 0;
    item_t q[$];

    logic [7:0] mdl_sr = 8'h00;
    logic [7:0] mdl_next = 8'h00;
    bit mdl_pend = 0;
    int clr_exp = 0;

    spi_sr_wp #(.WCYC(WCYC)) u_spi_sr_wp (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .si(si),
        .wp_n(wp_n), .wel(wel), .so(so), .so_oe(so_oe),
        .status(status), .wel_clr(wel_clr)
    );

    initial forever #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && wel_clr) clr_seen++;
        if (!rst && status[0]) busy_cnt++;
        else if (busy_cnt != 0) begin busy_last = busy_cnt; busy_cnt = 0; end
    end

    initial begin
        forever begin
            @(negedge clk);
            if (q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                check({it.req, " status"}, 32'(status), 32'(it.exp));
                check({it.req, " wel_clr count"}, clr_seen, it.clr_exp);
            end
        end
    end

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wrsr(input logic [7:0] op, input logic [7:0] data, input int nbits,
                        input bit mode3, input bit wel_in, input bit wp_low_start,
                        input int wp_drop_at, input bit wp_after, input bit settle,
                        input string req);
        logic [16:0] fr;
        bit oe_seen;
        bit accept;
        fr = {op, data, 1'b0};
        oe_seen = 0;
        wel = wel_in;
        if (wp_low_start) wp_n = 1'b0;
        sck = mode3;
        wait_n(2);
        cs_n = 1'b0;
        wait_n(2);
        for (int i = 0; i < nbits; i++) begin
            if (i == wp_drop_at) wp_n = 1'b0;
            if (mode3) sck = 1'b0;
            si = fr[16-i];
            wait_n(2);
            if (so_oe) oe_seen = 1;
            sck = 1'b1;
            if (i == wp_drop_at) wp_n = 1'b1;
            wait_n(2);
            if (!mode3) sck = 1'b0;
        end
        wait_n(2);
        cs_n = 1'b1;
        check({req, " R10 so_oe during frame"}, 32'(oe_seen), 0);
        accept = (nbits == 16) && (op == 8'h01) && wel_in && !mdl_pend &&
                 !(mdl_sr[7] && (wp_low_start || wp_drop_at >= 0));
        if (accept) begin
            mdl_next = data & 8'h8C;
            mdl_pend = 1;
            clr_exp++;
        end
        if (wp_after) begin
            wait_n(3);
            wp_n = 1'b0;
        end
        if (settle) begin
            wait_n(WCYC + 10);
            wp_n = 1'b1;
            if (mdl_pend) begin
                mdl_sr = mdl_next;
                mdl_pend = 0;
                wel = 1'b0;
            end
            q.push_back('{exp: mdl_sr | {6'b0, wel, 1'b0}, clr_exp: clr_exp, req: req});
            wait_n(2);
        end else begin
            wait_n(2);
        end
    endtask

    initial begin
        wait_n(4);
        rst = 1'b0;
        wait_n(1);
        check("R1 reset status", 32'(status), 0);
        check("R1 reset so_oe", 32'(so_oe), 0);
        check("R1 reset wel_clr", 32'(wel_clr), 0);

        // op, data, bits, mode3, wel, wp_low_start, wp_drop_at, wp_after, settle
        wrsr(8'h01, 8'h0C, 16, 0, 1, 0, -1, 0, 1, "R2 R11 mode0 write");
        wrsr(8'h01, 8'hFF, 16, 1, 1, 0, -1, 0, 1, "R3 R11 mode3 all-ones masked");
        wrsr(8'h01, 8'h00, 16, 0, 0, 0, -1, 0, 1, "R4 no wel ignored");
        wrsr(8'h01, 8'h00, 16, 1, 1, 1, -1, 0, 1, "R5 wp low inhibits");
        wrsr(8'h01, 8'h00, 16, 0, 1, 0, 10, 0, 1, "R6 wp pulse mid-frame cancels");
        wrsr(8'h01, 8'h04, 16, 0, 1, 0, -1, 1, 1, "R7 wp after start no effect");
        wrsr(8'h01, 8'h88, 16, 0, 1, 1, -1, 0, 1, "R8 wp ignored when pen clear");
        wrsr(8'h01, 8'h04, 15, 0, 1, 0, -1, 0, 1, "R2 15 bits discarded");
        wrsr(8'h01, 8'h04, 17, 1, 1, 0, -1, 0, 1, "R2 17 bits discarded");
        wrsr(8'h02, 8'h04, 16, 0, 1, 0, -1, 0, 1, "R2 wrong opcode discarded");

        wrsr(8'h01, 8'h00, 16, 0, 1, 0, -1, 0, 0, "R9 first write");
        check("R9 busy bit set", 32'(status[0]), 1);
        wrsr(8'h01, 8'h8C, 16, 1, 1, 0, -1, 0, 1, "R9 write during busy ignored");
        check("R9 busy length", busy_last, WCYC);
        check("R10 so_oe idle", 32'(so_oe), 0);

        wait_n(4);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule